// File: doc/BRIEF.md
# PCI Bus Parity Generator and Checker

This block produces the parity bit for a 32-bit PCI agent and checks the parity bit that other agents drive. In every clock it takes the sampled address/data lines and the command/byte-enable lines (active low). It registers their even parity and presents it on the parity output one clock later. The parity output enable is the agent's own address/data drive enable delayed by one clock. The parity pin is therefore driven exactly in the cycle after the agent drove the data it covers, and it is released one clock after the agent releases the address/data lines.

As a checker, the block finds the address phase and the completed data phases from the framing and ready strobes. Role and direction flags decide which of those phases this agent received from another agent. For each such phase, it compares the parity sampled one clock later with the parity it computed itself. A mismatch gives a one-clock error pulse. The policy for reporting the error to the system is left to the surrounding agent.

Top module: `pci_par_unit`

## Requirements
- R1: The parity output in cycle t+1 is the XOR of all 32 address/data bits and all 4 command/byte-enable bits sampled in cycle t, so the 37 bits together hold an even number of ones. This holds in every cycle, whatever the bus phase.
- R2: The parity output does not depend on the current cycle's address/data or command lines. A change to those lines within a cycle leaves the parity output unchanged until the next clock edge.
- R3: The parity output enable in cycle t+1 equals the address/data drive enable of cycle t. The enable therefore drops one clock after the address/data drive is released.
- R4: An address phase is a cycle in which FRAME (active low) is asserted after a cycle in which both FRAME and IRDY were deasserted. A target (master flag 0) checks the address parity, and a master (master flag 1) does not.
- R5: A write data phase is one cycle with both IRDY and TRDY asserted (low) and the write flag at 1. The target checks its parity, and the master does not.
- R6: A read data phase is one cycle with both IRDY and TRDY asserted and the write flag at 0. The master checks its parity, and the target does not.
- R7: The parity sampled in the cycle after a checked phase is compared with the parity computed for that phase. On a mismatch, the error output is high for exactly the one cycle after that comparison, so it appears two clocks after the phase. On a match it stays low.
- R8: A cycle with IRDY or TRDY deasserted that is not an address phase is never checked, even if the parity that follows it is wrong.
- R9: During and right after reset (active-low), the parity output, the parity output enable and the error output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ad_i | input | 32 | Sampled address/data lines |
| cbe_n_i | input | 4 | Sampled command/byte-enable lines, active low |
| ad_oe_i | input | 1 | This agent drives the address/data lines this cycle |
| frame_n_i | input | 1 | Sampled FRAME strobe, active low |
| irdy_n_i | input | 1 | Sampled initiator-ready strobe, active low |
| trdy_n_i | input | 1 | Sampled target-ready strobe, active low |
| is_master_i | input | 1 | 1 when this agent is the bus master of the current transaction |
| is_write_i | input | 1 | 1 when the current transaction is a write |
| par_i | input | 1 | Sampled parity pin |
| par_o | output | 1 | Parity value to drive |
| par_oe_o | output | 1 | Parity output enable |
| par_err_o | output | 1 | One-cycle parity error pulse |

## Verification
Several generator patterns are used: all zeros, all ones, a single bit in the top data lane, a single command bit, and mixed words. Together they show whether every byte lane and every command bit reaches the XOR. Changing the data in the middle of a cycle separates a registered parity from a combinational one. On the checker side, each phase kind (address, write data, read data) is run in both roles with correct and with flipped parity. The error pulse therefore shows both the role decode and the comparison. Wait-state cycles carrying bad parity confirm that only completed transfers are checked.

// File: rtl/pci_par_pkg.sv
package pci_par_pkg;

    // State of the phase decoder
    typedef struct packed {
        logic idle;   // previous cycle had FRAME and IRDY both released
        logic chk;    // previous cycle was a phase this agent must check
    } phase_st_t;

    // State of the top-level parity path
    typedef struct packed {
        logic par;      // parity of the previous cycle's lines
        logic oe;       // delayed drive enable
        logic err;      // mismatch pulse
        logic past_ok;  // one full cycle has elapsed since reset
    } unit_st_t;

endpackage

// File: rtl/pci_par_tree.sv
module pci_par_tree #(
    parameter int AD_W = 32,
    parameter int BE_W = 4
) (
    input  logic [AD_W-1:0] ad_i,
    input  logic [BE_W-1:0] cbe_n_i,
    output logic            par_o
);
    localparam int LANE_W = AD_W / BE_W;

    logic [BE_W-1:0] lane_par;

    // One reduction per byte lane, each folding in its own enable bit
    for (genvar g = 0; g < BE_W; g++) begin : g_lane
        assign lane_par[g] = ^{ad_i[g*LANE_W +: LANE_W], cbe_n_i[g]};
    end

    assign par_o = ^lane_par;

endmodule

// File: rtl/pci_par_phase.sv
module pci_par_phase
    import pci_par_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_n_i,
    input  logic irdy_n_i,
    input  logic trdy_n_i,
    input  logic is_master_i,
    input  logic is_write_i,
    output logic chk_o
);
    phase_st_t st_d, st_q;
    logic      addr_ph;
    logic      xfer;
    logic      data_ours;

    always_comb begin
        st_d      = st_q;
        addr_ph   = !frame_n_i && st_q.idle;
        xfer      = !irdy_n_i && !trdy_n_i;
        // Receiver of data: target on writes, master on reads
        data_ours = is_write_i ? !is_master_i : is_master_i;
        st_d.idle = frame_n_i && irdy_n_i;
        st_d.chk  = (addr_ph && !is_master_i) ||
                    (xfer && !addr_ph && data_ours);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{idle: 1'b1, chk: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign chk_o = st_q.chk;

    // R8
    no_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((irdy_n_i || trdy_n_i) && !addr_ph) |=> !chk_o);

    // R6
    rd_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_ph && !is_master_i && !is_write_i) |=> !chk_o);

    // R5
    wr_mst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_ph && is_master_i && is_write_i) |=> !chk_o);

endmodule

// File: rtl/pci_par_unit.sv
module pci_par_unit
    import pci_par_pkg::*;
#(
    parameter int AD_W = 32,
    parameter int BE_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AD_W-1:0] ad_i,
    input  logic [BE_W-1:0] cbe_n_i,
    input  logic            ad_oe_i,
    input  logic            frame_n_i,
    input  logic            irdy_n_i,
    input  logic            trdy_n_i,
    input  logic            is_master_i,
    input  logic            is_write_i,
    input  logic            par_i,
    output logic            par_o,
    output logic            par_oe_o,
    output logic            par_err_o
);
    unit_st_t st_d, st_q;
    logic     par_now;
    logic     chk;

    pci_par_tree #(.AD_W(AD_W), .BE_W(BE_W)) u_tree (
        .ad_i    (ad_i),
        .cbe_n_i (cbe_n_i),
        .par_o   (par_now)
    );

    pci_par_phase u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_n_i   (frame_n_i),
        .irdy_n_i    (irdy_n_i),
        .trdy_n_i    (trdy_n_i),
        .is_master_i (is_master_i),
        .is_write_i  (is_write_i),
        .chk_o       (chk)
    );

    always_comb begin
        st_d         = st_q;
        st_d.par     = par_now;
        st_d.oe      = ad_oe_i;
        st_d.err     = chk && (par_i != st_q.par);
        st_d.past_ok = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign par_o     = st_q.par;
    assign par_oe_o  = st_q.oe;
    assign par_err_o = st_q.err;

    // R1
    par_gen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.past_ok |-> (par_o == $past(^{ad_i, cbe_n_i})));

    // R3
    par_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.past_ok |-> (par_oe_o == $past(ad_oe_i)));

    // R7
    err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.past_ok && par_err_o) |-> $past(chk));

endmodule

// File: tb/sim_pci_par_unit.sv
`timescale 1ns/1ps
module sim_pci_par_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ad = '0;
    logic [3:0]  cbe_n = '0;
    logic        ad_oe = 1'b0;
    logic        frame_n = 1'b1;
    logic        irdy_n = 1'b1;
    logic        trdy_n = 1'b1;
    logic        is_master = 1'b0;
    logic        is_write = 1'b0;
    logic        par_in = 1'b0;
    logic        par_out, par_oe, par_err;
    int          checks = 0;
    int          failures = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    pci_par_unit u0 (
        .clk(clk), .rst_n(rst_n), .ad_i(ad), .cbe_n_i(cbe_n), .ad_oe_i(ad_oe),
        .frame_n_i(frame_n), .irdy_n_i(irdy_n), .trdy_n_i(trdy_n),
        .is_master_i(is_master), .is_write_i(is_write), .par_i(par_in),
        .par_o(par_out), .par_oe_o(par_oe), .par_err_o(par_err)
    );

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    function automatic logic epar(logic [31:0] a, logic [3:0] c);
        return ^{a, c};
    endfunction

    task automatic go_idle();
        frame_n = 1'b1; irdy_n = 1'b1; trdy_n = 1'b1; par_in = 1'b0;
        cyc();
    endtask

    task automatic t_reset();
        #5;
        check("R9 par during reset", par_out, 1'b0);
        check("R9 oe during reset", par_oe, 1'b0);
        check("R9 err during reset", par_err, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        cyc();
        check("R9 par after reset", par_out, 1'b0);
        check("R9 err after reset", par_err, 1'b0);
    endtask

    task automatic t_gen(logic [31:0] a, logic [3:0] c);
        ad = a; cbe_n = c;
        cyc();
        check("R1 parity value", par_out, epar(a, c));
    endtask

    task automatic t_nocomb();
        logic p1;
        ad = 32'h0000_0001; cbe_n = 4'h0;
        cyc();
        p1 = par_out;
        check("R1 parity before change", p1, 1'b1);
        ad = 32'h0000_0003;
        #5;
        check("R2 no same-cycle path", par_out, p1);
        cyc();
        check("R2 updates after edge", par_out, 1'b0);
    endtask

    task automatic t_oe();
        ad_oe = 1'b1;
        cyc();
        check("R3 oe follows drive", par_oe, 1'b1);
        ad_oe = 1'b0;
        #5;
        check("R3 oe held after AD release", par_oe, 1'b1);
        cyc();
        check("R3 oe released one clock later", par_oe, 1'b0);
    endtask

    // Address phase followed by a wait cycle, so only the address is judged
    task automatic t_addr(logic mst, logic bad, logic exp_err, string req);
        logic [31:0] a;
        a = 32'hA5C3_0F17;
        is_master = mst; is_write = 1'b1;
        go_idle();
        frame_n = 1'b0; ad = a; cbe_n = 4'b0111;
        cyc();
        irdy_n = 1'b0; trdy_n = 1'b1; par_in = epar(a, 4'b0111) ^ bad;
        cyc();
        check(req, par_err, exp_err);
        frame_n = 1'b1; irdy_n = 1'b1; par_in = 1'b0;
        cyc();
        check("R7 pulse lasts one cycle", par_err, 1'b0);
    endtask

    task automatic t_data(logic mst, logic wr, logic bad, logic exp_err, string req);
        logic [31:0] a, d;
        a = 32'h1000_0040; d = 32'hDEAD_BEEF;
        is_master = mst; is_write = wr;
        go_idle();
        frame_n = 1'b0; ad = a; cbe_n = 4'b0110;
        cyc();
        frame_n = 1'b1; irdy_n = 1'b0; trdy_n = 1'b0; ad = d; cbe_n = 4'b0010;
        par_in = epar(a, 4'b0110);
        cyc();
        check("R4 correct address parity", par_err, 1'b0);
        irdy_n = 1'b1; trdy_n = 1'b1; par_in = epar(d, 4'b0010) ^ bad;
        cyc();
        check(req, par_err, exp_err);
        par_in = 1'b0;
        cyc();
        check("R7 pulse lasts one cycle", par_err, 1'b0);
    endtask

    task automatic t_wait();
        logic [31:0] d;
        d = 32'h0F0F_1234;
        is_master = 1'b0; is_write = 1'b1;
        go_idle();
        frame_n = 1'b0; ad = 32'h2000_0000; cbe_n = 4'b0111;
        cyc();
        frame_n = 1'b1; irdy_n = 1'b0; trdy_n = 1'b1; ad = d; cbe_n = 4'h0;
        par_in = epar(32'h2000_0000, 4'b0111);
        cyc();
        irdy_n = 1'b0; trdy_n = 1'b1; par_in = ~epar(d, 4'h0);
        cyc();
        irdy_n = 1'b1; par_in = 1'b0;
        cyc();
        check("R8 wait state not checked", par_err, 1'b0);
    endtask

    initial begin
        t_reset();
        t_gen(32'h0000_0000, 4'h0);
        t_gen(32'hFFFF_FFFF, 4'hF);
        t_gen(32'h8000_0000, 4'h0);
        t_gen(32'h0000_0000, 4'h8);
        t_gen(32'h1357_9BDF, 4'h5);
        t_gen(32'h0100_0000, 4'h1);
        t_nocomb();
        t_oe();
        t_addr(1'b0, 1'b1, 1'b1, "R4 target flags bad address parity");
        t_addr(1'b0, 1'b0, 1'b0, "R7 target no error on good address");
        t_addr(1'b1, 1'b1, 1'b0, "R4 master ignores address parity");
        t_data(1'b0, 1'b1, 1'b1, 1'b1, "R5 target flags bad write data");
        t_data(1'b1, 1'b1, 1'b1, 1'b0, "R5 master ignores write data");
        t_data(1'b1, 1'b0, 1'b1, 1'b1, "R6 master flags bad read data");
        t_data(1'b0, 1'b0, 1'b1, 1'b0, "R6 target ignores read data");
        t_data(1'b1, 1'b0, 1'b0, 1'b0, "R7 no error on good read data");
        t_wait();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule